// File: doc/BRIEF.md
# Serial Controller Status and Interrupt Flags

This block keeps the three interrupt-capable status flags of a serial communications controller: transmit holding register free, received character waiting, and a shared flag that reports either an idle transmitter or a change on one of the two modem status inputs. The flags appear as a 3-bit status field and as three active-low request lines meant to drive open-drain interrupt pins. Because the lines are active-low, several devices can share one wired interrupt net.

The CPU reaches the block through a chip-select strobe (`cs_n`, active low), a direction bit (`rw_wr`, 1 = write, 0 = read) and a register address. Address 0 is the data location: a write loads the transmit holding register and a read takes the receive holding register. Address 1 is the status register. An access takes effect on the clock edge where the strobe is first seen high again. A read therefore returns the flag value from before the read clears it.

The serial engines sit outside the block. They report through single-cycle pulses: holding register taken by the shifter, character received, and transmitter drained. The two modem inputs are asynchronous. Each one passes through a synchroniser before it is compared with its previous value.

Top module: `ser_stat_irq`

## Requirements
- R1: While `rst` is high, and after it falls, all status bits are 0 and `tx_rdy_n`, `rx_rdy_n` and `txe_chg_n` are 1. Reset acts without a clock.
- R2: `stat_bits[0]` is the transmit-ready bit, `stat_bits[1]` the receive-ready bit and `stat_bits[2]` the shared empty/change bit. `tx_rdy_n`, `rx_rdy_n` and `txe_chg_n` are always the inverse of bits 0, 1 and 2 respectively.
- R3: With `tx_enable` high, bit 0 is 1 while the transmit holding register is empty. A write to address 0 (`rw_wr`=1) clears bit 0 on the edge where `cs_n` returns high. A `thr_taken` pulse sets it again on the next edge.
- R4: Bit 0 reads 0 whenever `tx_enable` is low, whatever the holding register holds.
- R5: An `rx_char_done` pulse sets bit 1 on the next edge. A read of address 0 (`rw_wr`=0) clears it on the edge where `cs_n` returns high. While `cs_n` is still low the bit keeps its earlier value.
- R6: Bit 1 is cleared on the first edge with `rx_enable` low. It stays 0 while `rx_enable` is low, and `rx_char_done` pulses are ignored during that time.
- R7: A `tx_idle_evt` pulse sets bit 2. That cause is removed only by a write to address 0. A read of address 1 leaves bit 2 at 1 while this cause is present.
- R8: A level change on `dsr_n` or `dcd_n` sets bit 2 within SYNC_STAGES+1 clock edges. A read of address 1 (`rw_wr`=0) removes this cause at the end of the access.
- R9: A modem input level that already differs from the idle-high level when reset ends does not set bit 2.
- R10: Activity on `rw_wr` and `addr` while `cs_n` stays high has no effect. Writes to address 1 and any access to addresses 2 and 3 leave all status bits unchanged.
- R11: `bus_oe` is 1 exactly while `cs_n` is low and `rw_wr` is 0.
- R12: When an event pulse arrives on the same edge as the end of an access, these priorities apply. A received character wins over the clear from a data read. A data write wins over a `thr_taken` pulse and over a `tx_idle_evt` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, one access per low period |
| rw_wr | input | 1 | Access direction: 1 write, 0 read |
| addr | input | ADDR_W | Register address |
| tx_enable | input | 1 | Transmitter enabled |
| rx_enable | input | 1 | Receiver enabled |
| thr_taken | input | 1 | Pulse: shifter took the transmit holding register |
| rx_char_done | input | 1 | Pulse: receiver delivered a character |
| tx_idle_evt | input | 1 | Pulse: last loaded character fully shifted out |
| dsr_n | input | 1 | Data set ready modem input, asynchronous |
| dcd_n | input | 1 | Carrier detect modem input, asynchronous |
| stat_bits | output | 3 | Status bits 2..0 |
| bus_oe | output | 1 | Data bus drive enable during reads |
| tx_rdy_n | output | 1 | Transmit-ready request, active low |
| rx_rdy_n | output | 1 | Receive-ready request, active low |
| txe_chg_n | output | 1 | Transmitter-empty or modem-change request, active low |

## Verification
Directed sequences drive each flag through its set and clear events one at a time, including the case where an event pulse lands on the same edge as the end of an access. These sequences separate the two causes of the shared bit: a status read that leaves the bit set shows the transmitter-empty cause, and one that releases it shows the modem-change cause. A stretch with modem inputs held low through reset separates a real level change from a stale reset value. A seeded random mix of accesses, pulses, enable flips and modem toggles then checks that the flags stay independent of each other under orders the directed cases do not reach.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;

   // End-of-access events decoded from the CPU strobe
   typedef struct packed {
      logic wr_data;   // transmit holding register loaded
      logic rd_data;   // receive holding register taken
      logic rd_stat;   // status register read
   } acc_evt_t;

   localparam int unsigned STAT_W   = 3;
   localparam int unsigned BIT_TXR  = 0;
   localparam int unsigned BIT_RXR  = 1;
   localparam int unsigned BIT_TXEC = 2;

endpackage

// File: rtl/ser_stat_access.sv
module ser_stat_access
   import ser_stat_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned DATA_ADDR = 0,
   parameter int unsigned STAT_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rw_wr,
   input  logic [ADDR_W-1:0] addr,
   output acc_evt_t          evt,
   output logic              bus_oe
);

   if (ADDR_W < 1) begin : g_bad_w
      $error("ser_stat_access: ADDR_W must be at least 1");
   end
   if (DATA_ADDR == STAT_ADDR) begin : g_bad_map
      $error("ser_stat_access: data and status addresses must differ");
   end

   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   logic              cs_q;
   logic              rw_q;
   logic [ADDR_W-1:0] addr_q;
   logic              acc_end;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cs_q   <= 1'b1;
         rw_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         cs_q <= cs_n;
         if (!cs_n) begin
            rw_q   <= rw_wr;
            addr_q <= addr;
         end
      end
   end

   // trailing edge of an access: strobe was low, now high
   assign acc_end = !cs_q && cs_n;

   always_comb begin
      evt         = '0;
      evt.wr_data = acc_end &&  rw_q && (addr_q == DATA_A);
      evt.rd_data = acc_end && !rw_q && (addr_q == DATA_A);
      evt.rd_stat = acc_end && !rw_q && (addr_q == STAT_A);
   end

   assign bus_oe = !cs_n && !rw_wr;

   p_idle_no_evt_r10: assert property (@(posedge clk) disable iff (rst)
      (cs_n && cs_q) |-> (evt == '0));

   p_one_evt_r10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(evt));

endmodule

// File: rtl/ser_stat_edge_sync.sv
module ser_stat_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_n,
   output logic change
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ser_stat_edge_sync: STAGES must be at least 2");
   end

   localparam int unsigned PRIME    = STAGES + 1;
   localparam int unsigned PRIME_CW = $clog2(PRIME + 1);

   logic [STAGES-1:0]   chain;
   logic                prev;
   logic [PRIME_CW-1:0] prime_cnt;
   logic                primed;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_n};
         prev  <= chain[STAGES-1];
      end
   end

   // mask the reset-time fill of the chain
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prime_cnt <= '0;
      end else if (!primed) begin
         prime_cnt <= prime_cnt + 1'b1;
      end
   end

   assign primed = (prime_cnt == PRIME_CW'(PRIME));
   assign change = primed && (chain[STAGES-1] != prev);

   p_prime_hold_r9: assert property (@(posedge clk) disable iff (rst)
      primed |=> primed);

endmodule

// File: rtl/ser_stat_irq.sv
module ser_stat_irq
   import ser_stat_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_ADDR   = 0,
   parameter int unsigned STAT_ADDR   = 1,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MODEM_LINES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rw_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              tx_enable,
   input  logic              rx_enable,
   input  logic              thr_taken,
   input  logic              rx_char_done,
   input  logic              tx_idle_evt,
   input  logic              dsr_n,
   input  logic              dcd_n,
   output logic [STAT_W-1:0] stat_bits,
   output logic              bus_oe,
   output logic              tx_rdy_n,
   output logic              rx_rdy_n,
   output logic              txe_chg_n
);

   if (MODEM_LINES != 2) begin : g_bad_lines
      $error("ser_stat_irq: MODEM_LINES must be 2 (data set ready, carrier)");
   end

   acc_evt_t               evt;
   logic [MODEM_LINES-1:0] modem_in;
   logic [MODEM_LINES-1:0] modem_chg;
   logic                   thr_full;
   logic                   rx_q;
   logic                   temt_q;
   logic                   chg_q;

   ser_stat_access #(
      .ADDR_W   (ADDR_W),
      .DATA_ADDR(DATA_ADDR),
      .STAT_ADDR(STAT_ADDR)
   ) u_access (
      .clk   (clk),
      .rst   (rst),
      .cs_n  (cs_n),
      .rw_wr (rw_wr),
      .addr  (addr),
      .evt   (evt),
      .bus_oe(bus_oe)
   );

   assign modem_in = {dcd_n, dsr_n};

   for (genvar i = 0; i < MODEM_LINES; i++) begin : g_modem
      ser_stat_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst   (rst),
         .line_n(modem_in[i]),
         .change(modem_chg[i])
      );
   end

   // transmit holding register occupancy; a load wins over a take
   always_ff @(posedge clk or posedge rst) begin
      if (rst)              thr_full <= 1'b0;
      else if (evt.wr_data) thr_full <= 1'b1;
      else if (thr_taken)   thr_full <= 1'b0;
   end

   // receive ready; a new character wins over the read clear
   always_ff @(posedge clk or posedge rst) begin
      if (rst)               rx_q <= 1'b0;
      else if (!rx_enable)   rx_q <= 1'b0;
      else if (rx_char_done) rx_q <= 1'b1;
      else if (evt.rd_data)  rx_q <= 1'b0;
   end

   // transmitter-empty cause: removed only by loading the holding register
   always_ff @(posedge clk or posedge rst) begin
      if (rst)              temt_q <= 1'b0;
      else if (evt.wr_data) temt_q <= 1'b0;
      else if (tx_idle_evt) temt_q <= 1'b1;
   end

   // modem-change cause: removed by a status read
   always_ff @(posedge clk or posedge rst) begin
      if (rst)              chg_q <= 1'b0;
      else if (|modem_chg)  chg_q <= 1'b1;
      else if (evt.rd_stat) chg_q <= 1'b0;
   end

   always_comb begin
      stat_bits           = '0;
      stat_bits[BIT_TXR]  = tx_enable && !thr_full;
      stat_bits[BIT_RXR]  = rx_q;
      stat_bits[BIT_TXEC] = temt_q || chg_q;
   end

   assign tx_rdy_n  = !stat_bits[BIT_TXR];
   assign rx_rdy_n  = !stat_bits[BIT_RXR];
   assign txe_chg_n = !stat_bits[BIT_TXEC];

   p_load_clears_txr_r3: assert property (@(posedge clk) disable iff (rst)
      evt.wr_data |=> !stat_bits[BIT_TXR]);

   p_take_sets_txr_r3: assert property (@(posedge clk) disable iff (rst)
      (thr_taken && !evt.wr_data) |=> (stat_bits[BIT_TXR] || !tx_enable));

   p_read_clears_rxr_r5: assert property (@(posedge clk) disable iff (rst)
      (evt.rd_data && !rx_char_done) |=> !stat_bits[BIT_RXR]);

   p_rx_off_r6: assert property (@(posedge clk) disable iff (rst)
      !rx_enable |=> !stat_bits[BIT_RXR]);

   p_char_wins_r12: assert property (@(posedge clk) disable iff (rst)
      (rx_char_done && rx_enable) |=> stat_bits[BIT_RXR]);

   p_stat_read_keeps_temt_r7: assert property (@(posedge clk) disable iff (rst)
      (evt.rd_stat && temt_q && !evt.wr_data) |=> stat_bits[BIT_TXEC]);

   p_chg_sets_r8: assert property (@(posedge clk) disable iff (rst)
      (|modem_chg) |=> stat_bits[BIT_TXEC]);

endmodule

// File: tb/ser_stat_irq_tb.sv
module ser_stat_irq_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       cs_n, rw_wr;
   logic [1:0] addr;
   logic       tx_enable, rx_enable;
   logic       thr_taken, rx_char_done, tx_idle_evt;
   logic       dsr_n, dcd_n;
   logic [2:0] stat_bits;
   logic       bus_oe, tx_rdy_n, rx_rdy_n, txe_chg_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // bench model of the flags
   bit m_full, m_rx, m_temt, m_chg;

   always #2.5 clk = ~clk;

   ser_stat_irq dut_i (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rw_wr(rw_wr), .addr(addr),
      .tx_enable(tx_enable), .rx_enable(rx_enable),
      .thr_taken(thr_taken), .rx_char_done(rx_char_done),
      .tx_idle_evt(tx_idle_evt), .dsr_n(dsr_n), .dcd_n(dcd_n),
      .stat_bits(stat_bits), .bus_oe(bus_oe),
      .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .txe_chg_n(txe_chg_n)
   );

   function automatic logic [2:0] exp_stat();
      return {m_temt || m_chg, m_rx, tx_enable && !m_full};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      logic [2:0] e;
      e = exp_stat();
      chk({tag, " stat (R2)"}, {29'd0, stat_bits}, {29'd0, e});
      chk({tag, " pins (R2)"}, {29'd0, txe_chg_n, rx_rdy_n, tx_rdy_n}, {29'd0, ~e});
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // ev: bit0 thr_taken, bit1 rx_char_done, bit2 tx_idle_evt
   task automatic apply_ev(input logic [2:0] ev, input bit wr_end, input bit rd_end);
      if (wr_end) begin
         m_full = 1'b1;
         m_temt = 1'b0;
      end else begin
         if (ev[0]) m_full = 1'b0;
         if (ev[2]) m_temt = 1'b1;
      end
      if (rd_end) m_rx = 1'b0;
      if (ev[1] && rx_enable) m_rx = 1'b1;
   endtask

   task automatic pulse(input logic [2:0] ev);
      {tx_idle_evt, rx_char_done, thr_taken} = ev;
      cyc(1);
      {tx_idle_evt, rx_char_done, thr_taken} = 3'b000;
      apply_ev(ev, 1'b0, 1'b0);
   endtask

   // one access; pulses in ev coincide with its end edge
   task automatic access(input bit wr, input logic [1:0] a, input logic [2:0] ev,
                         input bit check_mid);
      cs_n = 1'b0; rw_wr = wr; addr = a;
      cyc(1);
      if (check_mid) begin
         chk_all("R5 during access");
         chk("R11 bus_oe in access", {31'd0, bus_oe}, {31'd0, !wr});
      end
      cs_n = 1'b1; rw_wr = $urandom_range(0, 1); addr = 2'($urandom_range(0, 3));
      {tx_idle_evt, rx_char_done, thr_taken} = ev;
      cyc(1);
      {tx_idle_evt, rx_char_done, thr_taken} = 3'b000;
      apply_ev(ev, wr && a == 2'd0, !wr && a == 2'd0);
      if (!wr && a == 2'd1) m_chg = 1'b0;
   endtask

   task automatic toggle_modem(input bit which);
      if (which) dcd_n = ~dcd_n; else dsr_n = ~dsr_n;
      cyc(4);
      m_chg = 1'b1;
   endtask

   initial begin
      cyc(20000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1'b1;
   end

   always @(posedge done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h0000_5a1d));
      rst = 1'b1; cs_n = 1'b1; rw_wr = 1'b0; addr = 2'd0;
      tx_enable = 1'b0; rx_enable = 1'b0;
      thr_taken = 1'b0; rx_char_done = 1'b0; tx_idle_evt = 1'b0;
      dsr_n = 1'b1; dcd_n = 1'b0;   // carrier already asserted at reset (R9)
      #1;
      chk("R1 stat in async reset", {29'd0, stat_bits}, 32'd0);
      chk("R1 pins in async reset", {29'd0, txe_chg_n, rx_rdy_n, tx_rdy_n}, 32'd7);
      cyc(3);
      rst = 1'b0;
      cyc(8);
      chk_all("R1 after reset");
      chk_all("R9 stale modem level ignored");

      // R11 bus enable
      rw_wr = 1'b1; cs_n = 1'b0; #1;
      chk("R11 write no drive", {31'd0, bus_oe}, 32'd0);
      rw_wr = 1'b0; #1;
      chk("R11 read drives", {31'd0, bus_oe}, 32'd1);
      cs_n = 1'b1; #1;
      chk("R11 idle no drive", {31'd0, bus_oe}, 32'd0);
      cyc(1);

      // R4 / R3 transmit ready
      chk_all("R4 tx disabled");
      tx_enable = 1'b1; cyc(1);
      chk_all("R3 empty THR ready");
      access(1'b1, 2'd0, 3'b000, 1'b0);
      chk_all("R3 load clears ready");
      tx_enable = 1'b0; pulse(3'b001);
      chk_all("R4 take while disabled");
      tx_enable = 1'b1; cyc(1);
      chk_all("R3 ready after take");

      // R5 receive ready
      rx_enable = 1'b1; cyc(1);
      pulse(3'b010);
      chk_all("R5 char sets ready");
      access(1'b0, 2'd0, 3'b000, 1'b1);
      chk_all("R5 read clears ready");

      // R6 receiver disable
      pulse(3'b010);
      rx_enable = 1'b0; cyc(1); m_rx = 1'b0;
      chk_all("R6 disable clears");
      pulse(3'b010);
      chk_all("R6 char ignored while off");
      rx_enable = 1'b1; cyc(1);

      // R7 transmitter empty held through status read
      pulse(3'b100);
      chk_all("R7 empty sets bit2");
      access(1'b0, 2'd1, 3'b000, 1'b0);
      chk_all("R7 status read keeps bit2");
      access(1'b1, 2'd0, 3'b000, 1'b0);
      chk_all("R7 load releases bit2");

      // R8 modem change cleared by status read
      toggle_modem(1'b0);
      chk_all("R8 dsr change sets bit2");
      access(1'b0, 2'd1, 3'b000, 1'b0);
      chk_all("R8 status read releases");
      toggle_modem(1'b1);
      chk_all("R8 dcd change sets bit2");
      access(1'b0, 2'd0, 3'b000, 1'b0);
      chk_all("R8 data read does not release");
      access(1'b0, 2'd1, 3'b000, 1'b0);

      // R10 strobe high and unused addresses
      pulse(3'b010);
      for (int i = 0; i < 6; i++) begin
         rw_wr = i[0]; addr = 2'(i); cyc(1);
      end
      chk_all("R10 no strobe no effect");
      access(1'b1, 2'd1, 3'b000, 1'b0);
      access(1'b0, 2'd2, 3'b000, 1'b0);
      access(1'b1, 2'd3, 3'b000, 1'b0);
      access(1'b0, 2'd3, 3'b000, 1'b0);
      chk_all("R10 other addresses no effect");

      // R12 coincident events
      access(1'b0, 2'd0, 3'b010, 1'b0);
      chk_all("R12 char wins over read clear");
      pulse(3'b001);
      access(1'b1, 2'd0, 3'b101, 1'b0);
      chk_all("R12 load wins over take and empty");

      // seeded random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0: access(1'b1, 2'd0, 3'(($urandom_range(0, 7)) & 3'b111), 1'b0);
            1: access(1'b0, 2'd0, 3'(($urandom_range(0, 1)) << 1), 1'b1);
            2: access(1'b0, 2'd1, 3'b000, 1'b1);
            3: access($urandom_range(0, 1), 2'($urandom_range(2, 3)), 3'b000, 1'b0);
            4: pulse(3'($urandom_range(1, 7)));
            5: toggle_modem($urandom_range(0, 1));
            6: begin tx_enable = ~tx_enable; cyc(1); end
            7: begin rx_enable = ~rx_enable; cyc(1); if (!rx_enable) m_rx = 1'b0; end
            default: cyc(1);
         endcase
         chk_all("R12 random mix");
      end

      done = 1'b1;
   end

endmodule